// File: doc/BRIEF.md
# Store Queue with Age-Ordered Load Forwarding

This block keeps memory operations in program order in a circular buffer with a head pointer (oldest) and a tail pointer (next free slot). Each slot is allocated as either a load or a store. A store fills in its address and its data separately, and they may arrive in either order, once each value is known. Neither value goes to the cache at that point. A store reaches the cache only when it is the oldest slot and is retired. It is then presented on a write port for that cycle.

A load that is about to read the cache names its own slot and its address. In the same cycle the block searches every slot older than that load, counting from the head. It finds the youngest older store whose address is known and equal to the load address. If that store also holds its data, the data is forwarded and takes priority over the cache. If the data is still missing, the load is told to retry. If no older store matches, the load takes its value from the cache. The search gives correct answers wherever the load sits and whether or not the buffer has wrapped.

A flush cuts the buffer back to a named slot, discarding that slot and every younger one. Full and empty are told apart by a wrap bit carried on each pointer. The depth must be a power of two.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1, `q_full`=0), `alloc_idx` is 0, `retire_ok` and `mem_wr_en` are 0 and `lk_result` is 2'b00.
- R2: An accepted `alloc_req` places a new slot at the index shown on `alloc_idx` and advances it by one, modulo DEPTH. `alloc_is_store`=1 makes the slot a store, 0 a load. A request while `q_full`=1 is ignored.
- R3: After DEPTH allocations with no retirement, `q_full`=1 and `q_empty`=0, even though head and tail name the same slot. `q_full` and `q_empty` are never both 1.
- R4: With `lk_en`=1 and `lk_idx` an occupied load slot, the block selects the youngest slot older than the load that is a store with a known address equal to `lk_addr`. If that store has its data, `lk_result`=2'b01 and `lk_data` is that data.
- R5: Stores younger than the load, stores with a different address and stores whose address is not yet written never match. When nothing matches, `lk_result`=2'b00 (read the cache).
- R6: If the selected store has no data yet, `lk_result`=2'b10 (retry), even when an older matching store does hold data. `lk_data` is 0 whenever `lk_result` is not 2'b01.
- R7: R4 to R6 hold when the load slot index is lower than the head index, so that the older stores lie on both sides of the buffer's end.
- R8: With `retire_req`=1, the head slot retires (`retire_ok`=1) if it is a load, or a store holding both address and data. A retiring store drives `mem_wr_en`=1 with its address and data in that same cycle. A store lacking either value does not retire, and the queue is unchanged.
- R9: With `flush_req`=1 and `flush_idx` an occupied slot, that slot and every younger slot are freed, and `alloc_idx` becomes `flush_idx` on the next cycle. In that cycle all other requests are ignored. A flush naming a free slot is ignored as a whole.
- R10: Address or data writes (`sta_we`, `std_we`) that name a load slot or a free slot have no effect.
- R11: With `lk_en`=0, or with `lk_idx` naming a free slot or a store slot, `lk_result`=2'b00 and `lk_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Allocate a slot at the tail |
| alloc_is_store | input | 1 | 1: new slot is a store, 0: a load |
| alloc_idx | output | IW | Index the next allocation will take |
| q_full | output | 1 | All DEPTH slots occupied |
| q_empty | output | 1 | No slot occupied |
| sta_we | input | 1 | Write a store address |
| sta_idx | input | IW | Slot receiving the address |
| sta_addr | input | AW | Store address |
| std_we | input | 1 | Write store data |
| std_idx | input | IW | Slot receiving the data |
| std_data | input | DW | Store data |
| lk_en | input | 1 | Load lookup request |
| lk_idx | input | IW | Slot of the looking-up load |
| lk_addr | input | AW | Load address |
| lk_result | output | 2 | 00 cache, 01 forwarded, 10 retry |
| lk_data | output | DW | Forwarded data |
| retire_req | input | 1 | Retire the head slot |
| retire_ok | output | 1 | Head slot retires this cycle |
| mem_wr_en | output | 1 | Cache write of the retiring store |
| mem_wr_addr | output | AW | Cache write address |
| mem_wr_data | output | DW | Cache write data |
| flush_req | input | 1 | Cut the queue back to a slot |
| flush_idx | input | IW | First slot to discard |

## Verification
On every cycle the assertions check several properties. Full and empty never coincide, and the occupancy never exceeds the depth. The tail stays put while the queue is full. A cache write advances the head by one, and nothing retires from an empty queue. After a flush the occupancy equals the distance from head to the flushed slot. Load slots never carry address or data flags, and any non-cache lookup result points at a slot strictly older than the load. Only the bench's scenarios, compared each cycle against a behavioural queue model, show other behaviour. That covers which of several matching stores is chosen, retry versus forward when the nearest match lacks data, correct results across the wrapped end, and that writes to load or free slots leave lookups unchanged.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  typedef enum logic [1:0] {
    LK_CACHE = 2'b00,
    LK_FWD   = 2'b01,
    LK_WAIT  = 2'b10
  } lk_code_e;

endpackage

// File: rtl/sfq_ptrs.sv
module sfq_ptrs #(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_fire,
  input  logic                         retire_fire,
  input  logic                         flush_fire,
  input  logic [$clog2(DEPTH):0]       flush_keep,
  output logic [$clog2(DEPTH)-1:0]     head_idx,
  output logic [$clog2(DEPTH)-1:0]     tail_idx,
  output logic [$clog2(DEPTH):0]       count,
  output logic                         full,
  output logic                         empty
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;

  logic [PW-1:0] head_ptr, tail_ptr;

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p, input logic [PW-1:0] n);
    return p + n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else if (flush_fire) begin
      tail_ptr <= ptr_step(head_ptr, flush_keep);
    end else begin
      if (alloc_fire)  tail_ptr <= ptr_step(tail_ptr, PW'(1));
      if (retire_fire) head_ptr <= ptr_step(head_ptr, PW'(1));
    end
  end

  assign head_idx = head_ptr[IW-1:0];
  assign tail_idx = tail_ptr[IW-1:0];
  assign count    = tail_ptr - head_ptr;
  assign empty    = (tail_ptr == head_ptr);
  assign full     = (tail_ptr[IW] != head_ptr[IW]) && (tail_idx == head_idx);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));
  a_r3_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  a_r2_full_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush_fire) |=> $stable(tail_ptr));
  a_r9_flush_count: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |=> count == $past(flush_keep));

endmodule

// File: rtl/sfq_entries.sv
module sfq_entries #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc_fire,
  input  logic                             alloc_is_store,
  input  logic [$clog2(DEPTH)-1:0]         tail_idx,
  input  logic                             retire_fire,
  input  logic [$clog2(DEPTH)-1:0]         head_idx,
  input  logic                             flush_fire,
  input  logic [$clog2(DEPTH)-1:0]         flush_idx,
  input  logic                             sta_fire,
  input  logic [$clog2(DEPTH)-1:0]         sta_idx,
  input  logic [AW-1:0]                    sta_addr,
  input  logic                             std_fire,
  input  logic [$clog2(DEPTH)-1:0]         std_idx,
  input  logic [DW-1:0]                    std_data,
  output logic [DEPTH-1:0]                 valid,
  output logic [DEPTH-1:0]                 is_st,
  output logic [DEPTH-1:0]                 aok,
  output logic [DEPTH-1:0]                 dok,
  output logic [DEPTH-1:0][AW-1:0]         addr_arr,
  output logic [DEPTH-1:0][DW-1:0]         data_arr
);
  localparam int IW = $clog2(DEPTH);

  function automatic logic [IW-1:0] age_of(input logic [IW-1:0] idx, input logic [IW-1:0] hd);
    return idx - hd;
  endfunction

  logic [IW-1:0] flush_age;
  assign flush_age = age_of(flush_idx, head_idx);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic alloc_hit, retire_hit, kill_hit, sta_hit, std_hit;

    assign alloc_hit  = alloc_fire && (tail_idx == IW'(i));
    assign retire_hit = retire_fire && (head_idx == IW'(i));
    assign kill_hit   = flush_fire && (age_of(IW'(i), head_idx) >= flush_age);
    assign sta_hit    = sta_fire && (sta_idx == IW'(i)) && valid[i] && is_st[i];
    assign std_hit    = std_fire && (std_idx == IW'(i)) && valid[i] && is_st[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[i]    <= 1'b0;
        is_st[i]    <= 1'b0;
        aok[i]      <= 1'b0;
        dok[i]      <= 1'b0;
        addr_arr[i] <= '0;
        data_arr[i] <= '0;
      end else if (kill_hit) begin
        valid[i] <= 1'b0;
        aok[i]   <= 1'b0;
        dok[i]   <= 1'b0;
      end else if (alloc_hit) begin
        valid[i] <= 1'b1;
        is_st[i] <= alloc_is_store;
        aok[i]   <= 1'b0;
        dok[i]   <= 1'b0;
      end else begin
        if (retire_hit) valid[i] <= 1'b0;
        if (sta_hit) begin
          aok[i]      <= 1'b1;
          addr_arr[i] <= sta_addr;
        end
        if (std_hit) begin
          dok[i]      <= 1'b1;
          data_arr[i] <= std_data;
        end
      end
    end

    a_r10_load_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[i] && !is_st[i]) |-> (!aok[i] && !dok[i]));
  end

endmodule

// File: rtl/sfq_search.sv
module sfq_search
  import sfq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [$clog2(DEPTH)-1:0]         head_idx,
  input  logic [DEPTH-1:0]                 valid,
  input  logic [DEPTH-1:0]                 is_st,
  input  logic [DEPTH-1:0]                 aok,
  input  logic [DEPTH-1:0]                 dok,
  input  logic [DEPTH-1:0][AW-1:0]         addr_arr,
  input  logic [DEPTH-1:0][DW-1:0]         data_arr,
  input  logic                             lk_en,
  input  logic [$clog2(DEPTH)-1:0]         lk_idx,
  input  logic [AW-1:0]                    lk_addr,
  output lk_code_e                         code,
  output logic [DW-1:0]                    fwd_data
);
  localparam int IW = $clog2(DEPTH);

  function automatic logic [IW-1:0] age_of(input logic [IW-1:0] idx, input logic [IW-1:0] hd);
    return idx - hd;
  endfunction

  function automatic logic slot_match(input logic st, input logic known,
                                      input logic [AW-1:0] a, input logic [AW-1:0] want);
    return st && known && (a == want);
  endfunction

  logic          ld_ok;
  logic [IW-1:0] ld_age;
  logic          found;
  logic [IW-1:0] sel;
  logic [IW-1:0] sel_age;

  assign ld_ok  = lk_en && valid[lk_idx] && !is_st[lk_idx];
  assign ld_age = age_of(lk_idx, head_idx);

  // Scan from oldest to youngest; the last hit below the load's age wins.
  always_comb begin
    found   = 1'b0;
    sel     = '0;
    sel_age = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW-1:0] kk;
      logic [IW-1:0] e;
      kk = IW'(k);
      e  = head_idx + kk;
      if (kk < ld_age && slot_match(is_st[e], aok[e], addr_arr[e], lk_addr)) begin
        found   = 1'b1;
        sel     = e;
        sel_age = kk;
      end
    end
  end

  always_comb begin
    if (!ld_ok || !found) code = LK_CACHE;
    else if (dok[sel])    code = LK_FWD;
    else                  code = LK_WAIT;
  end

  assign fwd_data = (code == LK_FWD) ? data_arr[sel] : '0;

  a_r4_sel_older: assert property (@(posedge clk) disable iff (!rst_n)
    (code != LK_CACHE) |-> (sel_age < ld_age));
  a_r6_sel_is_store: assert property (@(posedge clk) disable iff (!rst_n)
    (code != LK_CACHE) |-> (valid[sel] && is_st[sel] && addr_arr[sel] == lk_addr));
  a_r11_idle_cache: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> (code == LK_CACHE && fwd_data == '0));

endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
  import sfq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          alloc_is_store,
  output logic [IW-1:0] alloc_idx,
  output logic          q_full,
  output logic          q_empty,
  input  logic          sta_we,
  input  logic [IW-1:0] sta_idx,
  input  logic [AW-1:0] sta_addr,
  input  logic          std_we,
  input  logic [IW-1:0] std_idx,
  input  logic [DW-1:0] std_data,
  input  logic          lk_en,
  input  logic [IW-1:0] lk_idx,
  input  logic [AW-1:0] lk_addr,
  output logic [1:0]    lk_result,
  output logic [DW-1:0] lk_data,
  input  logic          retire_req,
  output logic          retire_ok,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          flush_req,
  input  logic [IW-1:0] flush_idx
);
  logic [IW-1:0]             head_idx, tail_idx;
  logic [IW:0]               count;
  logic [IW:0]               flush_keep;
  logic [DEPTH-1:0]          valid, is_st, aok, dok;
  logic [DEPTH-1:0][AW-1:0]  addr_arr;
  logic [DEPTH-1:0][DW-1:0]  data_arr;
  logic                      flush_fire, alloc_fire, retire_fire, head_ready;
  logic                      sta_fire, std_fire;
  lk_code_e                  code;

  assign flush_fire  = flush_req && valid[flush_idx];
  assign flush_keep  = {1'b0, IW'(flush_idx - head_idx)};
  assign alloc_fire  = alloc_req && !q_full && !flush_fire;
  assign head_ready  = valid[head_idx] && (!is_st[head_idx] || (aok[head_idx] && dok[head_idx]));
  assign retire_fire = retire_req && head_ready && !flush_fire;
  assign sta_fire    = sta_we && !flush_fire;
  assign std_fire    = std_we && !flush_fire;

  sfq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .retire_fire(retire_fire),
    .flush_fire (flush_fire),
    .flush_keep (flush_keep),
    .head_idx   (head_idx),
    .tail_idx   (tail_idx),
    .count      (count),
    .full       (q_full),
    .empty      (q_empty)
  );

  sfq_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_entries (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_fire    (alloc_fire),
    .alloc_is_store(alloc_is_store),
    .tail_idx      (tail_idx),
    .retire_fire   (retire_fire),
    .head_idx      (head_idx),
    .flush_fire    (flush_fire),
    .flush_idx     (flush_idx),
    .sta_fire      (sta_fire),
    .sta_idx       (sta_idx),
    .sta_addr      (sta_addr),
    .std_fire      (std_fire),
    .std_idx       (std_idx),
    .std_data      (std_data),
    .valid         (valid),
    .is_st         (is_st),
    .aok           (aok),
    .dok           (dok),
    .addr_arr      (addr_arr),
    .data_arr      (data_arr)
  );

  sfq_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .head_idx(head_idx),
    .valid   (valid),
    .is_st   (is_st),
    .aok     (aok),
    .dok     (dok),
    .addr_arr(addr_arr),
    .data_arr(data_arr),
    .lk_en   (lk_en),
    .lk_idx  (lk_idx),
    .lk_addr (lk_addr),
    .code    (code),
    .fwd_data(lk_data)
  );

  assign lk_result   = code;
  assign alloc_idx   = tail_idx;
  assign retire_ok   = retire_fire;
  assign mem_wr_en   = retire_fire && is_st[head_idx];
  assign mem_wr_addr = addr_arr[head_idx];
  assign mem_wr_data = data_arr[head_idx];

  a_r8_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> head_idx == $past(head_idx) + IW'(1));
  a_r8_empty_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !retire_ok);
  a_r9_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |-> (!retire_ok && !mem_wr_en));

endmodule

// File: tb/store_fwd_queue_test.sv
module store_fwd_queue_test;
  localparam int CLK_PER = 10;
  localparam int D  = 8;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_req, alloc_is_store;
  logic [IW-1:0] alloc_idx;
  logic          q_full, q_empty;
  logic          sta_we, std_we, lk_en, retire_req, flush_req;
  logic [IW-1:0] sta_idx, std_idx, lk_idx, flush_idx;
  logic [AW-1:0] sta_addr, lk_addr, mem_wr_addr;
  logic [DW-1:0] std_data, lk_data, mem_wr_data;
  logic [1:0]    lk_result;
  logic          retire_ok, mem_wr_en;

  always #(CLK_PER/2) clk = ~clk;

  store_fwd_queue #(.DEPTH(D), .AW(AW), .DW(DW)) uut (.*);

  typedef struct {
    bit          st;
    bit          aok;
    bit          dok;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } ment_t;

  ment_t mq[$];
  int    hd = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;

  function automatic int posof(int x);
    int p;
    p = (x - hd + D) % D;
    return (p < mq.size()) ? p : -1;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    alloc_req = 0; alloc_is_store = 0;
    sta_we = 0; sta_idx = '0; sta_addr = '0;
    std_we = 0; std_idx = '0; std_data = '0;
    lk_en = 0; lk_idx = '0; lk_addr = '0;
    retire_req = 0; flush_req = 0; flush_idx = '0;
  endtask

  // Inputs are set after a falling edge; compare, take the rising edge, update the model.
  task automatic step(string tag);
    int  fp, p, sz;
    bit  fl, rok, wr;
    int  ecode;
    longint edata;
    #2;
    chk(tag, "q_full",  q_full,  mq.size() == D);
    chk(tag, "q_empty", q_empty, mq.size() == 0);
    chk(tag, "alloc_idx", alloc_idx, (hd + mq.size()) % D);
    fp  = posof(flush_idx);
    fl  = flush_req && (fp >= 0);
    rok = retire_req && !fl && mq.size() > 0 && (!mq[0].st || (mq[0].aok && mq[0].dok));
    wr  = rok && mq[0].st;
    chk(tag, "retire_ok", retire_ok, rok);
    chk(tag, "mem_wr_en", mem_wr_en, wr);
    if (wr) begin
      chk(tag, "mem_wr_addr", mem_wr_addr, mq[0].a);
      chk(tag, "mem_wr_data", mem_wr_data, mq[0].d);
    end
    ecode = 0; edata = 0;
    p = posof(lk_idx);
    if (lk_en && p >= 0 && !mq[p].st) begin
      for (int j = p - 1; j >= 0; j--) begin
        if (mq[j].st && mq[j].aok && mq[j].a == lk_addr) begin
          ecode = mq[j].dok ? 1 : 2;
          edata = mq[j].dok ? longint'(mq[j].d) : 0;
          break;
        end
      end
    end
    chk(tag, "lk_result", lk_result, ecode);
    chk(tag, "lk_data", lk_data, edata);
    @(posedge clk);
    sz = mq.size();
    if (fl) begin
      while (mq.size() > fp) void'(mq.pop_back());
    end else begin
      p = posof(sta_idx);
      if (sta_we && p >= 0 && mq[p].st) begin mq[p].aok = 1; mq[p].a = sta_addr; end
      p = posof(std_idx);
      if (std_we && p >= 0 && mq[p].st) begin mq[p].dok = 1; mq[p].d = std_data; end
      if (rok) begin void'(mq.pop_front()); hd = (hd + 1) % D; end
      if (alloc_req && sz < D) begin
        ment_t n;
        n.st = alloc_is_store; n.aok = 0; n.dok = 0; n.a = '0; n.d = '0;
        mq.push_back(n);
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic do_alloc(bit st, string tag);
    alloc_req = 1; alloc_is_store = st; step(tag);
  endtask

  task automatic wr_addr(int i, int a, string tag);
    sta_we = 1; sta_idx = IW'(i); sta_addr = AW'(a); step(tag);
  endtask

  task automatic wr_data(int i, int dv, string tag);
    std_we = 1; std_idx = IW'(i); std_data = DW'(dv); step(tag);
  endtask

  task automatic look(int i, int a, string tag);
    lk_en = 1; lk_idx = IW'(i); lk_addr = AW'(a); step(tag);
  endtask

  task automatic ret(string tag);
    retire_req = 1; step(tag);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1");                          // reset state
    // R2: fill with S L S S L S L L at slots 0..7
    do_alloc(1, "R2"); do_alloc(0, "R2"); do_alloc(1, "R2"); do_alloc(1, "R2");
    do_alloc(0, "R2"); do_alloc(1, "R2"); do_alloc(0, "R2"); do_alloc(0, "R2");
    do_alloc(1, "R3");                   // full: ignored
    step("R3");
    wr_addr(0, 'h100, "R4"); wr_data(0, 'hA0, "R4");
    wr_addr(2, 'h100, "R6");
    wr_addr(3, 'h200, "R4"); wr_data(3, 'hC3, "R4");
    wr_addr(1, 'h100, "R10"); wr_data(1, 'hEE, "R10");   // load slot: no effect
    look(1, 'h100, "R4");                // forward slot 0
    look(4, 'h100, "R6");                // nearest match slot 2 lacks data
    look(4, 'h200, "R4");
    look(4, 'h300, "R5");
    look(1, 'h200, "R5");                // only a younger store matches
    look(2, 'h100, "R11");               // store slot
    lk_en = 0; lk_idx = 3'd4; lk_addr = 'h100; step("R11");
    look(6, 'h100, "R10");               // load slot 1 wrote nothing
    wr_data(2, 'hB2, "R6");
    look(4, 'h100, "R4");
    ret("R8"); ret("R8"); ret("R8"); ret("R8"); ret("R8");
    ret("R8");                           // slot 5 incomplete: held
    step("R8");
    // R7: wrap, new slots 0..4
    do_alloc(1, "R7"); do_alloc(0, "R7"); do_alloc(1, "R7"); do_alloc(0, "R7"); do_alloc(1, "R7");
    wr_addr(5, 'h400, "R7"); wr_data(5, 'h55, "R7");
    wr_addr(0, 'h400, "R7"); wr_data(0, 'h50, "R7");
    look(1, 'h400, "R7");
    look(6, 'h400, "R7");
    wr_addr(2, 'h400, "R7");
    look(3, 'h400, "R7");
    ret("R8");                           // slot 5 now complete
    flush_req = 1; flush_idx = 3'd5; alloc_req = 1; alloc_is_store = 0; step("R9");  // free slot: ignored
    flush_req = 1; flush_idx = 3'd1; alloc_req = 1; retire_req = 1; step("R9");
    step("R9");
    look(1, 'h400, "R9");
    look(7, 'h400, "R11");
    // mixed traffic against the model
    for (int c = 0; c < 4000; c++) begin
      alloc_req      = ($urandom_range(0, 1) == 1);
      alloc_is_store = ($urandom_range(0, 1) == 1);
      sta_we   = ($urandom_range(0, 2) == 0);
      sta_idx  = IW'($urandom_range(0, D - 1));
      sta_addr = AW'($urandom_range(0, 3));
      std_we   = ($urandom_range(0, 2) == 0);
      std_idx  = IW'($urandom_range(0, D - 1));
      std_data = DW'($urandom());
      lk_en    = ($urandom_range(0, 3) != 0);
      lk_idx   = IW'($urandom_range(0, D - 1));
      lk_addr  = AW'($urandom_range(0, 3));
      retire_req = ($urandom_range(0, 2) == 0);
      flush_req  = ($urandom_range(0, 40) == 0);
      flush_idx  = IW'($urandom_range(0, D - 1));
      step("R7");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule